// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is a synchronous serial port that moves 8-bit words over a four-wire SPI link. It can run as the bus master, generating the serial clock and the active-low select, or as a slave that follows a select and clock supplied from outside. Software sets it up through four 16-bit registers on a simple write strobe and address interface. Reads are combinational. Each direction holds a single word: one waiting to be sent and the last one received.

In master mode the serial clock is derived from the system clock by two dividers in series. The first is an even prescaler and the second is a rate field plus one. A clock-polarity bit sets the idle level of the serial clock, and a phase bit selects which edge samples data. In slave mode the clock, select and data pins are brought into the system clock domain and their edges are detected there. A loopback switch feeds the port's own output back into its receiver. A slave-side gate can keep the MISO driver turned off.

Register map: address 0 is configuration, 1 is control, 2 is data and 3 is prescale.

Top module: `spi_port`

## Requirements
- R1: After reset, all four registers read zero, `ssel_n_o` is high, and `sclk_oe`, `mosi_oe`, `ssel_oe` and `miso_oe` are all low.
- R2: In the prescale register (address 3), bit 0 always reads 0. A prescale of 0 or 1 acts as a prescale of 2.
- R3: In master mode each SCLK level lasts (P/2)×(R+1) system clocks. P is the prescale and R is the rate field in bits 15:8 of the configuration register (address 0). A whole bit therefore takes P×(R+1) clocks.
- R4: Configuration bit 6 sets the idle level of SCLK. Configuration bit 7 selects the sampling edge. With bit 7 = 0, data is sampled on each edge that leaves the idle level. With bit 7 = 1, data is sampled on each edge that returns to it. A frame has 16 edges and carries 8 bits, MSB first. The output bit changes on the non-sampling edges, except on the first edge of a frame.
- R5: When the port is enabled with control bit 2 = 0 (master), `sclk_oe`, `mosi_oe` and `ssel_oe` are high and `miso_oe` is low. A queued word starts a frame: `ssel_n_o` goes low for the whole frame, and the received bits come from `miso_i`.
- R6: With control bit 2 = 1 (slave), only `miso_oe` can be high. A frame runs while the synchronised `ssel_n_i` is low. The port shifts out the queued word on `miso_o` and receives from `mosi_i`.
- R7: With control bit 3 set in slave mode, `miso_oe` stays low for the whole frame.
- R8: With control bit 0 set (loopback), the receiver takes the port's own serial output, and the receive pin has no effect on the received word.
- R9: With control bit 1 (enable) clear, the port drives no output enable and starts no frame. A word written to the data register in this state is sent once the port is enabled.
- R10: A write to control bit 2 has no effect while the enable bit is 1.
- R11: Control bit 4 reads 1 while a frame is in progress and 0 otherwise.
- R12: A write to the data register (address 2) queues an 8-bit word for sending. A read returns the last complete word received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master) |
| ssel_n_o | output | 1 | Active-low select out (master) |
| ssel_oe | output | 1 | Select output enable |
| ssel_n_i | input | 1 | Active-low select in (slave) |

## Verification
The bound checker enforces these on every cycle:
- A disabled port stays silent.
- Master and slave drivers are never enabled together.
- The output-disable gate holds MISO off.
- The mode bit stays fixed while the port is enabled.
- Busy covers the whole master frame.
- SCLK sits at its idle level at frame start and stays still between frames.

The bench scenarios are needed for the rest:
- the exact half-period count for each prescale and rate pair;
- the sampling edge and bit order in all four clock formats;
- the words exchanged in both roles;
- loopback ignoring the pin;
- a word queued while disabled being sent only after enable.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW     = 8,
  parameter int RATE_W = 8,
  parameter int PSC_W  = 8,
  parameter int BUS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             sclk_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             miso_i,
  output logic             ssel_n_o,
  output logic             ssel_oe,
  input  logic             ssel_n_i
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int BW    = $clog2(DW);
  localparam int HW    = PSC_W - 1;
  localparam logic [1:0]    A_CFG  = 2'd0;
  localparam logic [1:0]    A_CTL  = 2'd1;
  localparam logic [1:0]    A_DAT  = 2'd2;
  localparam logic [HW-1:0] H_ONE  = 1;
  localparam logic [EW-1:0] E_LAST = EW'(EDGES);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  logic [RATE_W-1:0] rate_q;
  logic              cpha_q, cpol_q;
  logic              loop_q, en_q, slave_q, sod_q;
  logic [HW-1:0]     psc_q;

  logic [DW-1:0]     tx_buf, rx_data, sh_tx, sh_rx;
  logic              tx_pend;
  logic [BW-1:0]     bit_cnt;
  logic              s_first;

  logic              m_act, sclk_q;
  logic [EW-1:0]     edge_cnt;
  logic [HW-1:0]     pre_cnt;
  logic [RATE_W-1:0] scr_cnt;

  logic [2:0]        sclk_r, ssel_r;
  logic [1:0]        mosi_r;

  logic              busy;
  logic              unused_bits;

  wire [HW-1:0] pre_lim  = (psc_q == '0) ? H_ONE : psc_q;
  wire          pre_wrap = (pre_cnt == pre_lim - H_ONE);
  wire          tick     = m_act && pre_wrap && (scr_cnt == rate_q);
  wire          m_start  = en_q && !slave_q && !m_act && tx_pend;
  wire          m_edge   = tick && (edge_cnt != E_LAST);
  wire          m_end    = tick && (edge_cnt == E_LAST);

  wire          s_act    = en_q && slave_q && !ssel_r[1];
  wire          s_start  = s_act && ssel_r[2];
  wire          s_edge   = s_act && !s_start && (sclk_r[1] != sclk_r[2]);

  wire          fr_start = m_start || s_start;
  wire          ev       = slave_q ? s_edge : m_edge;
  wire          lead     = slave_q ? (sclk_r[2] == cpol_q) : (sclk_q == cpol_q);
  wire          fr_first = slave_q ? s_first : (edge_cnt == '0);
  wire          samp     = ev && (lead ^ cpha_q);
  wire          shft     = ev && !(lead ^ cpha_q) && !fr_first;
  wire          rx_in    = loop_q ? sh_tx[DW-1] : (slave_q ? mosi_r[1] : miso_i);
  wire [DW-1:0] rx_next  = {sh_rx[DW-2:0], rx_in};

  assign busy        = m_act || s_act;
  assign unused_bits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      loop_q  <= 1'b0;
      en_q    <= 1'b0;
      slave_q <= 1'b0;
      sod_q   <= 1'b0;
      psc_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CFG: begin
          rate_q <= bus_wdata[BUS_W-1 -: RATE_W];
          cpha_q <= bus_wdata[7];
          cpol_q <= bus_wdata[6];
        end
        A_CTL: begin
          loop_q <= bus_wdata[0];
          en_q   <= bus_wdata[1];
          if (!en_q) slave_q <= bus_wdata[2];
          sod_q  <= bus_wdata[3];
        end
        A_DAT: ;
        default: psc_q <= bus_wdata[PSC_W-1:1];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r <= '0;
      ssel_r <= '1;
      mosi_r <= '0;
    end else begin
      sclk_r <= {sclk_r[1:0], sclk_i};
      ssel_r <= {ssel_r[1:0], ssel_n_i};
      mosi_r <= {mosi_r[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act    <= 1'b0;
      sclk_q   <= 1'b0;
      edge_cnt <= '0;
      pre_cnt  <= '0;
      scr_cnt  <= '0;
    end else if (!en_q || slave_q) begin
      m_act <= 1'b0;
    end else if (m_start) begin
      m_act    <= 1'b1;
      sclk_q   <= cpol_q;
      edge_cnt <= '0;
      pre_cnt  <= '0;
      scr_cnt  <= '0;
    end else if (m_act) begin
      if (pre_wrap) begin
        pre_cnt <= '0;
        scr_cnt <= (scr_cnt == rate_q) ? '0 : scr_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (m_edge) begin
        sclk_q   <= ~sclk_q;
        edge_cnt <= edge_cnt + 1'b1;
      end
      if (m_end) m_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_pend <= 1'b0;
      rx_data <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      bit_cnt <= '0;
      s_first <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_DAT) begin
        tx_buf  <= bus_wdata[DW-1:0];
        tx_pend <= 1'b1;
      end else if (fr_start) begin
        tx_pend <= 1'b0;
      end
      if (fr_start) begin
        sh_tx   <= tx_buf;
        sh_rx   <= '0;
        bit_cnt <= '0;
        s_first <= 1'b1;
      end else begin
        if (samp) begin
          sh_rx   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == B_LAST) rx_data <= rx_next;
        end
        if (shft) sh_tx <= {sh_tx[DW-2:0], 1'b0};
        if (s_edge) s_first <= 1'b0;
      end
    end
  end

  assign sclk_o   = m_act ? sclk_q : cpol_q;
  assign ssel_n_o = !m_act;
  assign mosi_o   = sh_tx[DW-1];
  assign miso_o   = sh_tx[DW-1];
  assign sclk_oe  = en_q && !slave_q;
  assign mosi_oe  = en_q && !slave_q;
  assign ssel_oe  = en_q && !slave_q;
  assign miso_oe  = s_act && !sod_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[BUS_W-1 -: RATE_W] = rate_q;
        bus_rdata[7] = cpha_q;
        bus_rdata[6] = cpol_q;
      end
      A_CTL:   bus_rdata[4:0] = {busy, sod_q, slave_q, en_q, loop_q};
      A_DAT:   bus_rdata[DW-1:0] = rx_data;
      default: bus_rdata[PSC_W-1:0] = {psc_q, 1'b0};
    endcase
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic slave_q,
  input logic sod_q,
  input logic cpol_q,
  input logic busy,
  input logic sclk_o,
  input logic sclk_oe,
  input logic miso_oe,
  input logic ssel_n_o
);
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (ssel_n_o && !sclk_oe && !miso_oe));

  p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_oe && miso_oe));

  p_miso_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sod_q |-> !miso_oe);

  p_mode_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(slave_q));

  p_busy_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ssel_n_o |-> busy);

  p_frame_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n_o) |-> (sclk_o == cpol_q));

  p_sclk_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ssel_n_o && $past(ssel_n_o) && $stable(cpol_q)) |-> $stable(sclk_o));

  p_slave_no_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slave_q |-> (ssel_n_o && !sclk_oe));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .slave_q(slave_q), .sod_q(sod_q),
  .cpol_q(cpol_q), .busy(busy), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .miso_oe(miso_oe), .ssel_n_o(ssel_n_o)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ssel_n_o, ssel_oe;
  logic sclk_i = 1'b0, mosi_i = 1'b0, miso_i, ssel_n_i = 1'b1;

  int n_cmp = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
    .ssel_n_o(ssel_n_o), .ssel_oe(ssel_oe), .ssel_n_i(ssel_n_i)
  );

  // Bench-side slave that answers the port in master mode
  logic       cpol_m = 1'b0, cpha_m = 1'b0;
  int         exp_half = 1;
  logic [7:0] bm_tx = 8'h0;
  logic [7:0] bm_rx, bm_sh;
  logic       prev_ssel, prev_sclk, bm_first;
  int         bm_gap, bm_edges, bm_bad_gap;

  always @(negedge clk) begin
    if (!rst_n) begin
      miso_i = 1'b0; prev_ssel = 1'b1; prev_sclk = 1'b0; bm_first = 1'b0;
      bm_rx = 8'h0; bm_sh = 8'h0; bm_gap = 0; bm_edges = 0; bm_bad_gap = 0;
    end else begin
      if (!ssel_n_o && prev_ssel) begin
        bm_first = 1'b1; bm_rx = 8'h0; bm_edges = 0; bm_gap = 0; bm_bad_gap = 0;
        bm_sh = bm_tx; miso_i = bm_tx[7]; prev_sclk = sclk_o;
      end else if (!ssel_n_o) begin
        bm_gap++;
        if (sclk_o != prev_sclk) begin
          bm_edges++;
          if (bm_gap != exp_half) bm_bad_gap++;
          bm_gap = 0;
          if ((prev_sclk == cpol_m) ^ cpha_m) bm_rx = {bm_rx[6:0], mosi_o};
          else if (!bm_first) begin bm_sh = bm_sh << 1; miso_i = bm_sh[7]; end
          bm_first = 1'b0;
          prev_sclk = sclk_o;
        end
      end
      prev_ssel = ssel_n_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int half_of(input logic [7:0] psc, input logic [7:0] scr);
    int h = int'(psc >> 1);
    if (h == 0) h = 1;
    return h * (int'(scr) + 1);
  endfunction

  task automatic wait_frame;
    int t = 0;
    while (ssel_n_o && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic wait_idle;
    int t = 0;
    while (!ssel_n_o && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic master_xfer(input logic pol, input logic pha, input logic [7:0] psc,
                             input logic [7:0] scr, input logic [7:0] tx,
                             input logic [7:0] sl, input logic lb);
    logic [15:0] r;
    wr(2'd1, 16'h0);
    wr(2'd3, {8'h0, psc});
    wr(2'd0, {scr, pha, pol, 6'h0});
    cpol_m = pol; cpha_m = pha; exp_half = half_of(psc, scr); bm_tx = sl;
    wr(2'd1, {12'h0, 1'b0, 1'b0, 1'b1, lb});
    chk("R5 master enables", {28'h0, sclk_oe, mosi_oe, ssel_oe, miso_oe}, 32'he);
    chk("R4 idle level", sclk_o, pol);
    wr(2'd2, {8'h0, tx});
    wait_frame();
    chk("R5 frame started", ssel_n_o, 0);
    rd(2'd1, r);
    chk("R11 busy in master frame", r[4], 1);
    wait_idle();
    rd(2'd1, r);
    chk("R11 busy clear after frame", r[4], 0);
    chk("R3 half period", bm_bad_gap, 0);
    chk("R4 edge count", bm_edges, 16);
    chk("R4 idle level after frame", sclk_o, pol);
    chk("R4 mosi bits seen by slave", bm_rx, tx);
    rd(2'd2, r);
    if (lb) chk("R8 loopback receive", r[7:0], tx);
    else    chk("R12 master receive", r[7:0], sl);
  endtask

  task automatic slave_xfer(input logic pol, input logic pha, input logic [7:0] tx,
                            input logic [7:0] md, input logic sod, input logic lb);
    logic [15:0] r;
    logic [7:0]  got;
    logic        samp;
    int          idx;
    wr(2'd1, 16'h0);
    wr(2'd0, {8'h0, pha, pol, 6'h0});
    wr(2'd1, {12'h0, sod, 1'b1, 1'b0, lb});
    wr(2'd1, {12'h0, sod, 1'b1, 1'b1, lb});
    wr(2'd2, {8'h0, tx});
    sclk_i = pol; mosi_i = md[7]; idx = 0; got = 8'h0;
    repeat (8) @(negedge clk);
    chk("R6 no master drivers", {29'h0, sclk_oe, mosi_oe, ssel_oe}, 0);
    chk("R6 miso off while deselected", miso_oe, 0);
    ssel_n_i = 1'b0;
    repeat (8) @(negedge clk);
    if (sod) chk("R7 miso held off", miso_oe, 0);
    else     chk("R6 miso driven in frame", miso_oe, 1);
    rd(2'd1, r);
    chk("R11 busy in slave frame", r[4], 1);
    for (int k = 0; k < 16; k++) begin
      samp = ((k % 2) == 0) ^ pha;
      if (samp) got = {got[6:0], miso_o};
      sclk_i = ~sclk_i;
      if (!samp && k > 0 && idx < 7) begin idx++; mosi_i = md[7 - idx]; end
      repeat (8) @(negedge clk);
    end
    ssel_n_i = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd1, r);
    chk("R11 busy clear after slave frame", r[4], 0);
    if (!sod) chk("R6 slave sent queued word", got, tx);
    rd(2'd2, r);
    if (lb) chk("R8 slave loopback receive", r[7:0], tx);
    else    chk("R6 slave receive", r[7:0], md);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int lows;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      chk("R1 register reset", r, 0);
    end
    chk("R1 select idle", ssel_n_o, 1);
    chk("R1 enables low", {28'h0, sclk_oe, mosi_oe, ssel_oe, miso_oe}, 0);

    wr(2'd3, 16'h0007); rd(2'd3, r); chk("R2 prescale bit0 reads 0", r, 16'h0006);
    wr(2'd3, 16'h0000); rd(2'd3, r); chk("R2 prescale zero", r, 0);

    master_xfer(1'b0, 1'b0, 8'd0, 8'd0, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b1, 1'b1, 8'd20, 8'd9, 8'h81, 8'h7E, 1'b0);
    master_xfer(1'b0, 1'b1, 8'd4, 8'd1, 8'hC3, 8'h3C, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] tx = 8'($urandom);
      master_xfer(1'($urandom), 1'($urandom), 8'(2 * (1 + $urandom % 4)),
                  8'($urandom % 4), tx, 8'($urandom), 1'b0);
    end

    // R9: word queued while disabled waits for enable
    wr(2'd1, 16'h0); wr(2'd3, 16'h0004); wr(2'd0, 16'h0);
    cpol_m = 1'b0; cpha_m = 1'b0; exp_half = 2; bm_tx = 8'h5A;
    wr(2'd2, 16'h0096);
    lows = 0;
    repeat (100) begin @(negedge clk); if (!ssel_n_o) lows++; end
    chk("R9 no frame while disabled", lows, 0);
    chk("R9 no drivers while disabled", {28'h0, sclk_oe, mosi_oe, ssel_oe, miso_oe}, 0);
    wr(2'd1, 16'h0002);
    wait_frame(); wait_idle();
    chk("R9 queued word sent after enable", bm_rx, 8'h96);
    rd(2'd2, r); chk("R12 received after enable", r[7:0], 8'h5A);

    // R10: mode bit locked while enabled
    wr(2'd1, 16'h0006); rd(2'd1, r);
    chk("R10 slave bit ignored while enabled", r[2], 0);
    chk("R10 still master", sclk_oe, 1);
    wr(2'd1, 16'h0000); wr(2'd1, 16'h0004); rd(2'd1, r);
    chk("R10 slave bit taken while disabled", r[2], 1);
    wr(2'd1, 16'h0006); wr(2'd1, 16'h0002); rd(2'd1, r);
    chk("R10 slave bit kept while enabled", r[2], 1);
    chk("R6 no clock drive in slave", sclk_oe, 0);

    slave_xfer(1'b0, 1'b0, 8'hB4, 8'h2D, 1'b0, 1'b0);
    slave_xfer(1'b1, 1'b0, 8'h17, 8'hE8, 1'b0, 1'b0);
    slave_xfer(1'b0, 1'b1, 8'h80, 8'h01, 1'b0, 1'b0);
    slave_xfer(1'b1, 1'b1, 8'h6C, 8'h93, 1'b0, 1'b0);
    slave_xfer(1'b0, 1'b0, 8'hF0, 8'h0F, 1'b1, 1'b0);
    slave_xfer(1'b1, 1'b0, 8'h5B, 8'hA4, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++)
      slave_xfer(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule